// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with APB Register Access

This block is a single 16-bit timer that sits as a slave on an APB bus. Software programs a start value, picks a clock divider and a counting mode, and enables the timer. The counter then steps down by one on every divided tick. When it steps from one to zero it raises a sticky interrupt request, which stays up until software writes to the clear register.

Two behaviours follow a zero count. In periodic mode the next tick reloads the counter from the stored start value, so the interrupt repeats at a fixed interval. In free-running mode the next tick wraps the counter to 0xFFFF and it runs through the whole 16-bit range. Writing the start value also loads the counter and restarts the divider, so a new interval begins at once.

Top module: `apb_down_timer`

## Requirements
- R1: After reset the reload value, current count, control word, divider state and interrupt are all zero.
- R2: Word offsets are decoded from paddr[3:2]: 0x0 reload value, 0x4 current count, 0x8 control, 0xC interrupt clear. A write to 0x0 stores pwdata[15:0] as the reload value, loads it into the counter on the same edge and restarts the divider. Reads of 0x0 and 0x4 return the 16-bit value zero-extended, and reads of 0xC return zero.
- R3: The current-count register is read-only. A write to offset 0x4 changes neither the count nor the reload value.
- R4: Control layout: bits [4:2] divider code, bit 6 mode (1 periodic, 0 free-running), bit 7 enable, bit 8 interrupt status (read-only). Bits [1:0], bit 5 and bits above 8 read as zero, and writes to them are ignored.
- R5: While enabled, the counter decrements once per divided tick. With divider code 0 that is once per clock.
- R6: Divider codes 0 to 7 divide the clock by 1, 16, 256, 2, 8, 32, 128 and 1024. With a start value L and divide D, the interrupt rises exactly L*D clocks after the enabling write.
- R7: The interrupt is set when the counter goes from 1 to 0 on a tick. It then stays set. The irq output equals control bit 8.
- R8: Any write to offset 0xC clears the interrupt, whatever its data. If a set and a clear happen on the same edge, the set wins.
- R9: In periodic mode, the tick after zero reloads the counter from the reload value.
- R10: In free-running mode, the tick after zero wraps the counter to 0xFFFF.
- R11: While disabled, the counter and the divider do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address; bits [3:2] select the register |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, decoded combinationally from paddr |
| irq | output | 1 | Level interrupt request, sticky until cleared |

## Verification
The assertions assume that a write is a single edge where psel, penable and pwrite are all high. They also assume that paddr and pwdata are stable over that edge, so that the $past of the write data is the value that was stored. The bench drives every transfer as a clean setup phase followed by an access phase, all on falling edges. It never holds the access phase over more than one rising edge, and it does not leave psel high between transfers. The same-edge set/clear case is reached by lining up a clear write with the divided tick that reaches zero, not by forcing internal state.

// File: rtl/apb_down_timer.sv
module apb_down_timer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 10
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);

  localparam logic [1:0] OFS_LOAD = 2'd0;
  localparam logic [1:0] OFS_CNT  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_CLR  = 2'd3;

  logic [CNT_W-1:0] reload_q, count_q;
  logic [PS_W-1:0]  pcnt_q, lim;
  logic [2:0]       div_code_q;
  logic             periodic_q, run_q, irq_q;

  wire [1:0] ofs     = paddr[3:2];
  wire       wr      = psel & penable & pwrite;
  wire       wr_load = wr && ofs == OFS_LOAD;
  wire       wr_ctrl = wr && ofs == OFS_CTRL;
  wire       wr_clr  = wr && ofs == OFS_CLR;

  always_comb begin
    case (div_code_q)
      3'd0:    lim = PS_W'(0);
      3'd1:    lim = PS_W'(15);
      3'd2:    lim = PS_W'(255);
      3'd3:    lim = PS_W'(1);
      3'd4:    lim = PS_W'(7);
      3'd5:    lim = PS_W'(31);
      3'd6:    lim = PS_W'(127);
      default: lim = PS_W'(1023);
    endcase
  end

  wire tick    = run_q && (pcnt_q >= lim);
  wire at_zero = count_q == '0;
  wire irq_set = tick && !wr_load && count_q == CNT_W'(1);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) pcnt_q <= '0;
    else if (wr_load || !run_q || tick) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (wr_load) begin
      reload_q <= pwdata[CNT_W-1:0];
      count_q  <= pwdata[CNT_W-1:0];
    end else if (tick) begin
      if (at_zero) count_q <= periodic_q ? reload_q : '1;
      else         count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      div_code_q <= '0;
      periodic_q <= 1'b0;
      run_q      <= 1'b0;
    end else if (wr_ctrl) begin
      div_code_q <= pwdata[4:2];
      periodic_q <= pwdata[6];
      run_q      <= pwdata[7];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)     irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (wr_clr)  irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    prdata = '0;
    case (ofs)
      OFS_LOAD: prdata[CNT_W-1:0] = reload_q;
      OFS_CNT:  prdata[CNT_W-1:0] = count_q;
      OFS_CTRL: prdata[8:0] = {irq_q, run_q, periodic_q, 1'b0, div_code_q, 2'b00};
      default:  prdata = '0;
    endcase
  end

  AST_LOAD_COUNT: assert property (@(posedge pclk) disable iff (!presetn)
    wr_load |=> count_q == $past(pwdata[CNT_W-1:0]) && reload_q == $past(pwdata[CNT_W-1:0])); // R2
  AST_CTRL_PADS: assert property (@(posedge pclk) disable iff (!presetn)
    ofs == OFS_CTRL |-> prdata[1:0] == 2'b00 && !prdata[5] && prdata[8] == irq); // R4
  AST_HOLD_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    !run_q && !wr_load |=> $stable(count_q)); // R11
  AST_IRQ_RISE: assert property (@(posedge pclk) disable iff (!presetn)
    run_q && !wr_load && count_q == CNT_W'(1) && pcnt_q >= lim |=> irq_q && count_q == '0); // R7
  AST_IRQ_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    irq_q && !wr_clr |=> irq_q); // R7
  AST_IRQ_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    wr_clr && !(tick && !wr_load && count_q == CNT_W'(1)) |=> !irq_q); // R8
  AST_PERIODIC_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
    tick && at_zero && periodic_q && !wr_load |=> count_q == $past(reload_q)); // R9
  AST_FREE_WRAP: assert property (@(posedge pclk) disable iff (!presetn)
    tick && at_zero && !periodic_q && !wr_load |=> count_q == '1); // R10

endmodule

// File: tb/sim_apb_down_timer.sv
module sim_apb_down_timer;
  localparam int CLK_PERIOD = 10;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_down_timer u0 (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  // value sampled one rising edge after the call; the call spans two rising edges
  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk) penable = 1;
    #1 d = prdata;
    @(negedge pclk) begin psel = 0; penable = 0; end
  endtask

  task automatic idle();
    apb_wr(4'h8, 32'h0);
    apb_wr(4'hC, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    apb_rd(4'h0, v); check(v == 0, "R1 reload", v, 0);
    apb_rd(4'h4, v); check(v == 0, "R1 count", v, 0);
    apb_rd(4'h8, v); check(v == 0, "R1 control", v, 0);
    check(irq == 0, "R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    apb_wr(4'h0, 32'hABCD1234);
    apb_rd(4'h0, v); check(v == 32'h1234, "R2 reload readback", v, 32'h1234);
    apb_rd(4'h4, v); check(v == 32'h1234, "R2 count loaded", v, 32'h1234);
    apb_rd(4'hC, v); check(v == 0, "R2 clear reads zero", v, 0);
    apb_wr(4'h4, 32'h5555);
    apb_rd(4'h4, v); check(v == 32'h1234, "R3 count ro", v, 32'h1234);
    apb_rd(4'h0, v); check(v == 32'h1234, "R3 reload untouched", v, 32'h1234);
    apb_wr(4'h8, 32'hFFFF_FE23);
    apb_rd(4'h8, v); check(v == 0, "R4 pad bits ignored", v, 0);
    apb_wr(4'h8, 32'h0000_005C);
    apb_rd(4'h8, v); check(v == 32'h5C, "R4 fields", v, 32'h5C);
    apb_wr(4'h8, 32'h0000_0100);
    apb_rd(4'h8, v); check(v == 0, "R4 status bit ro", v, 0);
  endtask

  task automatic t_decrement_hold();
    logic [31:0] v, w;
    idle();
    apb_wr(4'h0, 32'd10);
    apb_wr(4'h8, 32'h80);
    apb_rd(4'h4, v); check(v == 9, "R5 first step", v, 9);
    apb_rd(4'h4, v); check(v == 7, "R5 per clock", v, 7);
    apb_wr(4'h8, 32'h0);
    apb_rd(4'h4, v);
    repeat (20) @(negedge pclk);
    apb_rd(4'h4, w); check(w == v, "R11 hold when disabled", w, v);
  endtask

  task automatic t_periodic_irq();
    logic [31:0] v;
    idle();
    apb_wr(4'h0, 32'd3);
    apb_wr(4'h8, 32'hC0);
    @(negedge pclk); @(negedge pclk);
    check(irq == 0, "R7 no early irq", {31'b0, irq}, 0);
    @(negedge pclk);
    check(irq == 1, "R7 irq at zero", {31'b0, irq}, 1);
    apb_rd(4'h4, v); check(v == 3, "R9 periodic reload", v, 3);
    apb_rd(4'h8, v); check(v[8] == 1, "R7 status bit", v, 32'h1C0);
    check(irq == 1, "R7 sticky", {31'b0, irq}, 1);
    apb_wr(4'h8, 32'h0);
    apb_wr(4'hC, 32'hDEADBEEF);
    check(irq == 0, "R8 clear any data", {31'b0, irq}, 0);
  endtask

  task automatic t_free_wrap();
    logic [31:0] v;
    idle();
    apb_wr(4'h0, 32'd1);
    apb_wr(4'h8, 32'h80);
    apb_rd(4'h4, v); check(v == 0, "R10 reached zero", v, 0);
    apb_rd(4'h4, v); check(v == 32'hFFFE, "R10 wrap", v, 32'hFFFE);
    check(irq == 1, "R7 irq free-run", {31'b0, irq}, 1);
    apb_wr(4'h8, 32'h0);
  endtask

  task automatic t_set_beats_clear();
    idle();
    apb_wr(4'h0, 32'd1);
    apb_wr(4'h8, 32'h8C);
    apb_wr(4'hC, 32'h0);
    check(irq == 1, "R8 set wins over clear", {31'b0, irq}, 1);
    idle();
  endtask

  task automatic t_div(input logic [2:0] code, input int div, input int ld);
    idle();
    apb_wr(4'h0, 32'(ld));
    apb_wr(4'h8, 32'h80 | (32'(code) << 2));
    repeat (ld*div - 1) @(negedge pclk);
    check(irq == 0, $sformatf("R6 code %0d early", code), {31'b0, irq}, 0);
    @(negedge pclk);
    check(irq == 1, $sformatf("R6 code %0d on time", code), {31'b0, irq}, 1);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    t_reset();
    t_regs();
    t_decrement_hold();
    t_periodic_irq();
    t_free_wrap();
    t_set_beats_clear();
    t_div(3'd0, 1, 4);
    t_div(3'd1, 16, 3);
    t_div(3'd2, 256, 1);
    t_div(3'd3, 2, 5);
    t_div(3'd4, 8, 2);
    t_div(3'd5, 32, 1);
    t_div(3'd6, 128, 1);
    t_div(3'd7, 1024, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule